// File: doc/BRIEF.md
# GFP Receive Payload Header Processor

This block sits after core-header delineation and descrambling in a GFP receiver. It takes the payload area of one frame as a byte stream, marked with start and end flags. The stream opens with the two-byte Type field and its tHEC. When the extension mode calls for it, a four-byte linear extension header follows. The block checks these header fields against a control byte and a set of expected values. It then forwards the client bytes toward the MAC side with their own start and end flags.

Every header field check can be switched off through its own control bit. The Type header can be kept and placed in front of the client bytes instead of being removed. A frame that fails any enabled check is dropped whole, and so is a frame that ends before it carries any client byte. Each dropped frame adds one to a saturating error counter.

The forwarded bytes pass through a small commit buffer, which can use block RAM. Nothing from a frame is released until all of its headers have been accepted, so a dropped frame never reaches the output.

Top module: `gfp_rx_hdr_proc`

## Requirements
- R1: Control bit 7 sets the header layout. When it is 1, the frame has a 4-byte header (Type in bytes 0–1, tHEC in bytes 2–3) and client data starts at byte 4. When it is 0, an extension header fills bytes 4–7 and client data starts at byte 8.
- R2: When control bit 6 is 1, bytes 0–1 of an accepted frame are forwarded in front of the client bytes. When it is 0, they are not forwarded.
- R3: Unless control bit 3 is 1, the Type check requires all of the following: byte 0 bits 7:5 equal 000; byte 0 bits 3:0 equal 0 in 4-byte mode or 1 in 8-byte mode; byte 1 equals `cfg_upi`. Byte 0 bit 4 is never checked.
- R4: Unless control bit 4 is 1, bytes 2 (high) and 3 (low) must equal the CRC-16 of bytes 0 and 1. The CRC uses polynomial 0x1021, starts from zero and takes bits most significant first.
- R5: In 8-byte mode, three more checks apply. Byte 4 bits 7:4 must equal `cfg_dp` unless control bit 1 is 1. Byte 4 bits 3:0 must equal `cfg_sp` unless control bit 0 is 1. Bytes 6–7 must equal the CRC-16 (as in R4) of bytes 4 and 5 unless control bit 5 is 1.
- R6: In 8-byte mode with control bit 2 at 0, a frame whose byte 5 differs from `cfg_spare` is dropped and counted. With bit 2 at 1, byte 5 has no effect.
- R7: A dropped frame emits no output byte, and `err_count` rises by exactly one for it.
- R8: A frame whose end flag comes on or before its last header byte is dropped and counted.
- R9: Accepted frames are forwarded in input order. `out_sof` is high on the first byte emitted and `out_eof` on the byte that carried the input end flag.
- R10: `err_count` stops at its all-ones value.
- R11: After reset, `err_count` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | First byte of a frame payload area |
| in_eof | input | 1 | Last byte of a frame payload area |
| in_data | input | 8 | Input byte |
| cfg_ctrl | input | 8 | Control byte: mode, keep-Type and per-check inhibit bits |
| cfg_spare | input | 8 | Expected byte 5 of the extension header |
| cfg_upi | input | 8 | Expected Type byte 1 |
| cfg_dp | input | 4 | Expected upper nibble of extension byte 4 |
| cfg_sp | input | 4 | Expected lower nibble of extension byte 4 |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | Last forwarded byte of a frame |
| out_data | output | 8 | Forwarded byte |
| err_count | output | ERR_W | Saturating count of dropped frames |

## Verification
The bench sweeps all 256 control bytes. For each one it sends twelve frame patterns: a clean frame, one frame per header field with a single corruption (Type class, EXI, UPI, tHEC, DP, SP, Spare, eHEC), a frame with the ignored Type bit 4 set, a frame cut inside its header and a frame with no client byte. A corrupted field that is dropped only when its own inhibit bit is clear shows that the checks and inhibits are wired to the right fields. The same corruption passing in 4-byte mode shows that extension checks apply only in 8-byte mode. Comparing the output byte sequence with and without bit 6 separates header stripping from keeping the Type header. A narrow counter reaches saturation partway through the sweep.

// File: rtl/gfp_rx_pkg.sv
package gfp_rx_pkg;
  localparam logic [15:0] HEC_POLY = 16'h1021;
  localparam int HDR_LEN_NULL = 4;
  localparam int HDR_LEN_EXT  = 8;

  // control byte bit positions
  localparam int CTL_NULL_EXT   = 7;
  localparam int CTL_KEEP_TYPE  = 6;
  localparam int CTL_SKIP_EHEC  = 5;
  localparam int CTL_SKIP_THEC  = 4;
  localparam int CTL_SKIP_TYPE  = 3;
  localparam int CTL_SKIP_SPARE = 2;
  localparam int CTL_SKIP_DP    = 1;
  localparam int CTL_SKIP_SP    = 0;

  typedef struct packed {
    logic       sof;
    logic       eof;
    logic [7:0] data;
  } pay_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} rx_state_t;

  function automatic logic [15:0] hec_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? HEC_POLY : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/gfp_rx_hec.sv
module gfp_rx_hec
  import gfp_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seed,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [15:0] hec_q
);
  always_ff @(posedge clk) begin
    if (rst)       hec_q <= '0;
    else if (seed) hec_q <= hec_step(16'h0000, din);
    else if (step) hec_q <= hec_step(hec_q, din);
  end
endmodule

// File: rtl/gfp_rx_hdr_check.sv
module gfp_rx_hdr_check
  import gfp_rx_pkg::*;
#(
  parameter int IDX_W = $clog2(HDR_LEN_EXT)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  input  logic [7:0] cfg_ctrl,
  input  logic [7:0] cfg_spare,
  input  logic [7:0] cfg_upi,
  input  logic [3:0] cfg_dp,
  input  logic [3:0] cfg_sp,
  output logic       wr_en,
  output pay_word_t  wr_word,
  output logic       commit,
  output logic       rollback,
  output logic       err_inc
);
  rx_state_t        state_q;
  logic [IDX_W-1:0] idx_q, cur_idx, last_idx;
  logic [7:0]       type0_q, hold_q;
  logic             fail_q, first_q;
  logic [15:0]      hec_q;
  logic             start, hdr_byte, pay_byte, fail_now, fail_acc, decide, bad;
  logic             null_ext, keep_type;
  logic [3:0]       exi_want;

  assign null_ext  = cfg_ctrl[CTL_NULL_EXT];
  assign keep_type = cfg_ctrl[CTL_KEEP_TYPE];
  assign exi_want  = null_ext ? 4'd0 : 4'd1;
  assign last_idx  = null_ext ? IDX_W'(HDR_LEN_NULL - 1) : IDX_W'(HDR_LEN_EXT - 1);

  assign start    = in_valid && in_sof && (state_q == ST_IDLE);
  assign hdr_byte = start || (in_valid && state_q == ST_HDR);
  assign pay_byte = in_valid && (state_q == ST_PAY);
  assign cur_idx  = start ? '0 : idx_q;

  gfp_rx_hec hec_i (
    .clk  (clk),
    .rst  (rst),
    .seed (hdr_byte && (cur_idx == IDX_W'(0) || cur_idx == IDX_W'(4))),
    .step (hdr_byte && (cur_idx == IDX_W'(1) || cur_idx == IDX_W'(5))),
    .din  (in_data),
    .hec_q(hec_q)
  );

  always_comb begin
    fail_now = 1'b0;
    if (hdr_byte) begin
      case (cur_idx)
        IDX_W'(1): fail_now = !cfg_ctrl[CTL_SKIP_TYPE] &&
                              (type0_q[7:5] != 3'b000 || type0_q[3:0] != exi_want ||
                               in_data != cfg_upi);
        IDX_W'(3): fail_now = !cfg_ctrl[CTL_SKIP_THEC] && (hec_q != {hold_q, in_data});
        IDX_W'(4): fail_now = (!cfg_ctrl[CTL_SKIP_DP] && in_data[7:4] != cfg_dp) ||
                              (!cfg_ctrl[CTL_SKIP_SP] && in_data[3:0] != cfg_sp);
        IDX_W'(5): fail_now = !cfg_ctrl[CTL_SKIP_SPARE] && (in_data != cfg_spare);
        IDX_W'(7): fail_now = !cfg_ctrl[CTL_SKIP_EHEC] && (hec_q != {hold_q, in_data});
        default:   fail_now = 1'b0;
      endcase
    end
  end

  assign fail_acc = (start ? 1'b0 : fail_q) | fail_now;
  assign decide   = hdr_byte && (cur_idx == last_idx || in_eof);
  assign bad      = fail_acc || in_eof;
  assign err_inc  = decide && bad;
  assign rollback = err_inc;
  assign commit   = (decide && !bad) || pay_byte;

  assign wr_en        = (hdr_byte && keep_type && cur_idx < IDX_W'(2)) || pay_byte;
  assign wr_word.data = in_data;
  assign wr_word.sof  = hdr_byte ? (cur_idx == IDX_W'(0)) : first_q;
  assign wr_word.eof  = pay_byte && in_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      type0_q <= '0;
      hold_q  <= '0;
      fail_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (hdr_byte) begin
        idx_q  <= cur_idx + IDX_W'(1);
        fail_q <= fail_acc;
        if (cur_idx == IDX_W'(0)) type0_q <= in_data;
        if (cur_idx == IDX_W'(2) || cur_idx == IDX_W'(6)) hold_q <= in_data;
      end
      if (decide) begin
        state_q <= bad ? ST_IDLE : ST_PAY;
        first_q <= !keep_type;
      end else if (start) begin
        state_q <= ST_HDR;
      end
      if (pay_byte) begin
        first_q <= 1'b0;
        if (in_eof) state_q <= ST_IDLE;
      end
    end
  end

  // R7: a frame is either accepted or dropped, never both at once
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst) !(commit && rollback));
  // R7: no byte enters the buffer while no frame is open
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !in_sof) |-> !wr_en);
  // R9: the end flag of client data closes the frame
  p_eof_closes_r9: assert property (@(posedge clk) disable iff (rst)
    (pay_byte && in_eof) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/gfp_rx_commit_fifo.sv
module gfp_rx_commit_fifo
  import gfp_rx_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  pay_word_t wr_word,
  input  logic      commit,
  input  logic      rollback,
  output logic      rd_valid,
  output pay_word_t rd_word
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  pay_word_t     mem [DEPTH];
  logic [PW-1:0] wr_q, cmt_q, rd_q, wr_nxt;
  logic          rd_go;

  assign wr_nxt = rollback ? cmt_q : wr_q + PW'(wr_en);
  assign rd_go  = (rd_q != cmt_q);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_go) rd_word <= mem[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= '0;
      cmt_q    <= '0;
      rd_q     <= '0;
      rd_valid <= 1'b0;
    end else begin
      wr_q     <= wr_nxt;
      if (commit) cmt_q <= wr_nxt;
      rd_valid <= rd_go;
      if (rd_go) rd_q <= rd_q + PW'(1);
    end
  end

  // R9: the buffer never holds more than its depth, so no byte is lost or reordered
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_q - rd_q) <= PW'(DEPTH));
  // R7: released bytes never run past the accepted boundary
  p_read_behind_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (cmt_q - rd_q) <= (wr_q - rd_q));
endmodule

// File: rtl/gfp_rx_hdr_proc.sv
module gfp_rx_hdr_proc
  import gfp_rx_pkg::*;
#(
  parameter int ERR_W   = 16,
  parameter int FIFO_AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [7:0]       cfg_ctrl,
  input  logic [7:0]       cfg_spare,
  input  logic [7:0]       cfg_upi,
  input  logic [3:0]       cfg_dp,
  input  logic [3:0]       cfg_sp,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_data,
  output logic [ERR_W-1:0] err_count
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  pay_word_t wr_word, rd_word;
  logic      wr_en, commit, rollback, err_inc;

  gfp_rx_hdr_check chk_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .cfg_ctrl(cfg_ctrl), .cfg_spare(cfg_spare), .cfg_upi(cfg_upi),
    .cfg_dp(cfg_dp), .cfg_sp(cfg_sp),
    .wr_en(wr_en), .wr_word(wr_word), .commit(commit),
    .rollback(rollback), .err_inc(err_inc)
  );

  gfp_rx_commit_fifo #(.AW(FIFO_AW)) buf_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_word(wr_word), .commit(commit), .rollback(rollback),
    .rd_valid(out_valid), .rd_word(rd_word)
  );

  assign out_sof  = rd_word.sof;
  assign out_eof  = rd_word.eof;
  assign out_data = rd_word.data;

  always_ff @(posedge clk) begin
    if (rst)                               err_count <= '0;
    else if (err_inc && err_count != ERR_MAX) err_count <= err_count + ERR_W'(1);
  end

  // R7: the counter only ever moves up by one
  p_err_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_count) |-> (err_count == $past(err_count) + ERR_W'(1)));
  // R10: once full, the counter stays full
  p_err_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (err_count == ERR_MAX) |=> (err_count == ERR_MAX));
endmodule

// File: tb/gfp_rx_hdr_proc_tb_top.sv
module gfp_rx_hdr_proc_tb_top;
  localparam int ERR_W = 4;
  localparam int ERR_SAT = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, in_valid, in_sof, in_eof;
  logic [7:0] in_data, cfg_ctrl, cfg_spare, cfg_upi;
  logic [3:0] cfg_dp, cfg_sp;
  logic out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [ERR_W-1:0] err_count;

  int total = 0, bad = 0, exp_err = 0;
  bit done = 0;
  logic [9:0] obs[$];
  logic [9:0] expq[$];
  logic [7:0] frm[$];

  gfp_rx_hdr_proc #(.ERR_W(ERR_W), .FIFO_AW(3)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_ctrl(cfg_ctrl), .cfg_spare(cfg_spare), .cfg_upi(cfg_upi),
    .cfg_dp(cfg_dp), .cfg_sp(cfg_sp), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_data(out_data), .err_count(err_count)
  );

  always @(negedge clk) if (!rst && out_valid) obs.push_back({out_sof, out_eof, out_data});

  function automatic logic [15:0] crc2(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] c, d;
    logic fb;
    c = 16'h0; d = {a, b};
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (ctrl=%0h)", tag, what, act, exp, cfg_ctrl);
    end
  endtask

  // variants: 0 clean, 1 PTI, 2 UPI, 3 tHEC, 4 EXI, 5 DP, 6 SP, 7 Spare,
  // 8 eHEC, 9 cut in header, 10 no client byte, 11 bit 4 of byte 0 set
  task automatic build(input int v, input int plen);
    logic [7:0] b0, b1, cid, spr;
    logic [15:0] h;
    bit ext;
    int hl;
    ext = !cfg_ctrl[7];
    hl = ext ? 8 : 4;
    frm.delete();
    b0 = {3'b000, 1'b0, (ext ? 4'd1 : 4'd0)};
    if (v == 1) b0[7:5] = 3'b010;
    if (v == 4) b0[3:0] = ext ? 4'd0 : 4'd1;
    if (v == 11) b0[4] = 1'b1;
    b1 = cfg_upi ^ ((v == 2) ? 8'h01 : 8'h00);
    h = crc2(b0, b1);
    if (v == 3) h = h ^ 16'h0100;
    frm.push_back(b0); frm.push_back(b1); frm.push_back(h[15:8]); frm.push_back(h[7:0]);
    if (ext) begin
      cid = {cfg_dp ^ ((v == 5) ? 4'h1 : 4'h0), cfg_sp ^ ((v == 6) ? 4'h8 : 4'h0)};
      spr = cfg_spare ^ ((v == 7) ? 8'h80 : 8'h00);
      h = crc2(cid, spr);
      if (v == 8) h = h ^ 16'h0001;
      frm.push_back(cid); frm.push_back(spr); frm.push_back(h[15:8]); frm.push_back(h[7:0]);
    end
    for (int i = 0; i < plen; i++) frm.push_back(8'(8'h20 + i * 7 + v));
    if (v == 9)  while (frm.size() > hl - 1) void'(frm.pop_back());
    if (v == 10) while (frm.size() > hl) void'(frm.pop_back());
  endtask

  function automatic bit model_pass();
    bit ext;
    int hl;
    logic [15:0] h;
    ext = !cfg_ctrl[7];
    hl = ext ? 8 : 4;
    if (frm.size() <= hl) return 0;
    if (!cfg_ctrl[3] && (frm[0][7:5] != 3'b000 || frm[0][3:0] != (ext ? 4'd1 : 4'd0) || frm[1] != cfg_upi))
      return 0;
    h = crc2(frm[0], frm[1]);
    if (!cfg_ctrl[4] && {frm[2], frm[3]} != h) return 0;
    if (ext) begin
      if (!cfg_ctrl[1] && frm[4][7:4] != cfg_dp) return 0;
      if (!cfg_ctrl[0] && frm[4][3:0] != cfg_sp) return 0;
      if (!cfg_ctrl[2] && frm[5] != cfg_spare) return 0;
      h = crc2(frm[4], frm[5]);
      if (!cfg_ctrl[5] && {frm[6], frm[7]} != h) return 0;
    end
    return 1;
  endfunction

  task automatic run_frame(input int v, input int plen, input string vtag);
    bit pass;
    int hl, n;
    string ctag;
    build(v, plen);
    pass = model_pass();
    hl = cfg_ctrl[7] ? 4 : 8;
    expq.delete();
    if (pass) begin
      if (cfg_ctrl[6]) begin
        expq.push_back({2'b00, frm[0]});
        expq.push_back({2'b00, frm[1]});
      end
      for (int j = hl; j < frm.size(); j++) expq.push_back({2'b00, frm[j]});
      expq[0][9] = 1'b1;
      expq[expq.size() - 1][8] = 1'b1;
    end else begin
      exp_err = (exp_err < ERR_SAT) ? exp_err + 1 : ERR_SAT;
    end
    obs.delete();
    for (int i = 0; i < frm.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == frm.size() - 1); in_data = frm[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (10) @(negedge clk);
    // accept/drop decision and byte count: R7 when dropped
    check(obs.size() == expq.size(), pass ? vtag : {vtag, "/R7"}, obs.size(), expq.size(), "byte count");
    n = (obs.size() < expq.size()) ? obs.size() : expq.size();
    ctag = cfg_ctrl[6] ? "R2" : "R1";
    for (int j = 0; j < n; j++) begin
      check(obs[j][7:0] == expq[j][7:0], ctag, obs[j][7:0], expq[j][7:0], "data byte");
      check(obs[j][9:8] == expq[j][9:8], "R9", obs[j][9:8], expq[j][9:8], "sof/eof flags");
    end
    check(err_count == ERR_W'(exp_err), (!pass && exp_err == ERR_SAT) ? "R10" : "R7",
          err_count, exp_err, "drop counter");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tags[12];
    tags = '{"R1", "R3", "R3", "R4", "R3", "R5", "R5", "R6", "R5", "R8", "R8", "R3"};
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    cfg_ctrl = 8'h00; cfg_spare = 8'h00; cfg_upi = 8'h00; cfg_dp = 4'h0; cfg_sp = 4'h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", out_valid, 0, "out_valid after reset");
    check(err_count == '0, "R11", err_count, 0, "counter after reset");
    for (int c = 0; c < 256; c++) begin
      cfg_ctrl  = 8'(c);
      cfg_upi   = 8'(c * 3 + 1);
      cfg_dp    = 4'(c) ^ 4'h9;
      cfg_sp    = ~4'(c);
      cfg_spare = 8'hA5 ^ 8'(c);
      for (int v = 0; v < 12; v++) run_frame(v, (v % 4) + 1, tags[v]);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule